// File: doc/BRIEF.md
# Load/Store Data Alignment and Range Unit

This unit sits between a processor's load/store stage and a 32-bit data bus whose byte order puts the most significant part of a value at the lowest address. Each accepted request produces one registered bus beat. A double-word produces two beats. On a store, the unit places a byte or halfword on the correct byte lanes and sets the matching byte enables. It also checks that the register value fits the signed or unsigned range of the target width. A value that does not fit raises a trap and is not written.

On a load, the unit takes the addressed byte or halfword from the returned bus word. It moves that field to the low end of the result and extends it with zeros or with its sign bit, as the request selects. The unit reports misaligned halfword, word and double-word addresses. It suppresses the byte enables whenever an access is misaligned or a store traps.

A double-word access takes two consecutive beats. The beat at the lower address carries the high-order word. A `busy` flag marks the cycle in which the second beat is still owed. The requester must not issue a new access during that cycle.

Top module: `lsa_unit`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `bus_valid`, `bus_write`, `bus_be`, `beat_idx`, `busy`, `ld_valid`, `misalign` and `range_trap` are all 0.
- R2: A request accepted on a rising edge appears on the bus outputs after that edge. `bus_valid` is 1, `bus_write` equals `req_store` and `bus_addr` equals `req_addr`. The size encoding is 0 = byte, 1 = halfword, 2 = word, 3 = double-word. In a cycle with no beat, `bus_valid` is 0 and `bus_be` is 0000.
- R3: A byte store copies `req_wdata[7:0]` into all four lanes. Exactly one enable is set: address offset 0 selects `bus_be[3]` (bits 31:24), and offset 3 selects `bus_be[0]` (bits 7:0).
- R4: A halfword store copies `req_wdata[15:0]` into both halves, with enables 1100 at offset 0 and 0011 at offset 2. A word store drives `req_wdata[31:0]` unchanged with enables 1111.
- R5: An access sets `misalign` to 1 and `bus_be` to 0000 in either of two cases: a halfword with address bit 0 set, or a word or double-word with a nonzero address offset. A misaligned double-word produces no second beat. A byte access is never misaligned.
- R6: A byte store traps when the 32-bit value `req_wdata[31:0]` lies outside a range set by the signed select. The range is -128..127 when `req_signed` is 1 and 0..255 when it is 0. Halfword stores use -32768..32767 or 0..65535 in the same way. On a trap, `range_trap` is 1 and `bus_be` is 0000. Word and double-word stores, and all loads, never trap.
- R7: For a byte load, the byte lane selected by the offset, as in R3, is right-adjusted into `ld_data`. For a halfword load, `bus_rdata[31:16]` is used at offset 0 and `bus_rdata[15:0]` at offset 2. The field is zero-extended when `req_signed` was 0 and sign-extended when it was 1. A word load passes `bus_rdata` through. `ld_data` follows `bus_rdata` in the beat's own cycle. `ld_valid` is 1 exactly for an aligned load beat.
- R8: An aligned double-word first drives `req_wdata[63:32]` at `req_addr` with `beat_idx` 0 and `busy` 1. In the next cycle it drives `req_wdata[31:0]` at `req_addr`+4 with `beat_idx` 1, enables 1111 and `busy` 0.
- R9: A request presented while `busy` is 1 is ignored. The second beat keeps its address and data, and the following cycle has `bus_valid` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 double-word |
| req_signed | input | 1 | Signed range check / sign extension |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Register data; byte/half/word in [31:0], double-word high word in [63:32] |
| bus_rdata | input | 32 | Data returned by the bus for the current beat |
| busy | output | 1 | Second double-word beat owed next cycle |
| bus_valid | output | 1 | Beat present |
| bus_write | output | 1 | Beat is a store |
| bus_addr | output | ADDR_W | Beat address |
| bus_wdata | output | 32 | Lane-placed store data |
| bus_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| beat_idx | output | 1 | 0 first beat, 1 second double-word beat |
| ld_valid | output | 1 | Aligned load beat |
| ld_data | output | 32 | Right-adjusted, extended load result |
| misalign | output | 1 | Address violates the size's alignment |
| range_trap | output | 1 | Store value outside the target width's range |

## Verification
The hardest case to reach is a request that arrives during the single cycle in which a double-word's second beat is still owed. It only exists one edge after an aligned double-word is accepted. The bench issues such a double-word and presents a conflicting byte store in exactly that cycle. It then checks that the second beat still carries the held address and low word, and that no third beat appears. The range boundaries are reached by sweeping the values on either side of each limit, for both widths, both signed selects and every offset.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  // Alignment rule per access size
  function automatic logic misaligned(acc_size_e sz, logic [1:0] off);
    case (sz)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return off[0];
      default: return |off;
    endcase
  endfunction

  // Does a register value fit the width being stored?
  function automatic logic fits_range(acc_size_e sz, logic sgn, logic [WORD_W-1:0] v);
    case (sz)
      SZ_BYTE:
        if (sgn) return (v[WORD_W-1:7] == '0) || (v[WORD_W-1:7] == '1);
        else     return (v[WORD_W-1:8] == '0);
      SZ_HALF:
        if (sgn) return (v[WORD_W-1:15] == '0) || (v[WORD_W-1:15] == '1);
        else     return (v[WORD_W-1:16] == '0);
      default: return 1'b1;
    endcase
  endfunction

  // Right-adjusted field extension for byte/halfword loads
  function automatic logic [WORD_W-1:0] extend_field(logic [15:0] f, logic is_half, logic sgn);
    logic [WORD_W-1:0] r;
    if (is_half) r = {{(WORD_W-16){sgn & f[15]}}, f};
    else         r = {{(WORD_W-8){sgn & f[7]}}, f[7:0]};
    return r;
  endfunction

endpackage

// File: rtl/lsa_store_lane.sv
module lsa_store_lane
  import lsa_pkg::*;
(
  input  acc_size_e           sz,
  input  logic                sgn,
  input  logic                is_store,
  input  logic [1:0]          off,
  input  logic [WORD_W-1:0]   wd,
  output logic [WORD_W-1:0]   lane_data,
  output logic [LANES-1:0]    be,
  output logic                mis,
  output logic                trap
);

  logic [LANES-1:0] lane_mask;

  assign mis  = misaligned(sz, off);
  assign trap = is_store & ~fits_range(sz, sgn, wd);

  // Lane l carries bits [8l+7:8l]; it sits at address offset LANES-1-l
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [1:0] BYTE_OFF = 2'(LANES - 1 - l);
    localparam bit         HI_OF_HALF = (l % 2) == 1;
    localparam bit         LOW_HALF   = l < 2;
    always_comb begin
      case (sz)
        SZ_BYTE: begin
          lane_data[8*l +: 8] = wd[7:0];
          lane_mask[l]        = (off == BYTE_OFF);
        end
        SZ_HALF: begin
          lane_data[8*l +: 8] = HI_OF_HALF ? wd[15:8] : wd[7:0];
          lane_mask[l]        = (off[1] == LOW_HALF);
        end
        default: begin
          lane_data[8*l +: 8] = wd[8*l +: 8];
          lane_mask[l]        = 1'b1;
        end
      endcase
    end
  end

  assign be = lane_mask & {LANES{~(mis | trap)}};

endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
  import lsa_pkg::*;
(
  input  acc_size_e           sz,
  input  logic                sgn,
  input  logic [1:0]          off,
  input  logic [WORD_W-1:0]   rdata,
  output logic [WORD_W-1:0]   result
);

  logic [7:0]  lane_b [LANES];
  logic [7:0]  sel_byte;
  logic [15:0] sel_half;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_b[l] = rdata[8*l +: 8];
  end

  // Offset 0 is the most significant lane
  assign sel_byte = lane_b[~off];
  assign sel_half = off[1] ? rdata[15:0] : rdata[31:16];

  always_comb begin
    case (sz)
      SZ_BYTE: result = extend_field({8'h00, sel_byte}, 1'b0, sgn);
      SZ_HALF: result = extend_field(sel_half, 1'b1, sgn);
      default: result = rdata;
    endcase
  end

endmodule

// File: rtl/lsa_beat_seq.sv
module lsa_beat_seq
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  acc_size_e           req_size,
  input  logic                req_mis,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [WORD_W-1:0]   req_lo,
  output logic                accept,
  output logic                second,
  output logic [ADDR_W-1:0]   next_addr,
  output logic [WORD_W-1:0]   next_data
);

  logic                pend;
  logic [ADDR_W-1:0]   hold_addr;
  logic [WORD_W-1:0]   hold_lo;

  assign accept    = req_valid & ~pend;
  assign second    = pend;
  assign next_addr = hold_addr + ADDR_W'(4);
  assign next_data = hold_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      hold_addr <= '0;
      hold_lo   <= '0;
    end else if (pend) begin
      pend <= 1'b0;
    end else if (accept) begin
      pend      <= (req_size == SZ_DWORD) & ~req_mis;
      hold_addr <= req_addr;
      hold_lo   <= req_lo;
    end
  end

endmodule

// File: rtl/lsa_unit.sv
module lsa_unit
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_store,
  input  logic [1:0]          req_size,
  input  logic                req_signed,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [63:0]         req_wdata,
  input  logic [31:0]         bus_rdata,
  output logic                busy,
  output logic                bus_valid,
  output logic                bus_write,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [31:0]         bus_wdata,
  output logic [3:0]          bus_be,
  output logic                beat_idx,
  output logic                ld_valid,
  output logic [31:0]         ld_data,
  output logic                misalign,
  output logic                range_trap
);

  acc_size_e          in_size;
  logic [WORD_W-1:0]  in_word;
  logic [WORD_W-1:0]  st_data;
  logic [LANES-1:0]   st_be;
  logic               st_mis, st_trap;
  logic               accept, second;
  logic [ADDR_W-1:0]  nx_addr;
  logic [WORD_W-1:0]  nx_data;

  acc_size_e          cur_size;
  logic               cur_sgn;

  assign in_size = acc_size_e'(req_size);
  assign in_word = (in_size == SZ_DWORD) ? req_wdata[63:32] : req_wdata[31:0];

  lsa_store_lane u_store (
    .sz        (in_size),
    .sgn       (req_signed),
    .is_store  (req_store),
    .off       (req_addr[1:0]),
    .wd        (in_word),
    .lane_data (st_data),
    .be        (st_be),
    .mis       (st_mis),
    .trap      (st_trap)
  );

  lsa_beat_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_size  (in_size),
    .req_mis   (st_mis),
    .req_addr  (req_addr),
    .req_lo    (req_wdata[31:0]),
    .accept    (accept),
    .second    (second),
    .next_addr (nx_addr),
    .next_data (nx_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_valid  <= 1'b0;
      bus_write  <= 1'b0;
      bus_addr   <= '0;
      bus_wdata  <= '0;
      bus_be     <= '0;
      beat_idx   <= 1'b0;
      misalign   <= 1'b0;
      range_trap <= 1'b0;
      cur_size   <= SZ_BYTE;
      cur_sgn    <= 1'b0;
    end else if (second) begin
      bus_valid  <= 1'b1;
      bus_addr   <= nx_addr;
      bus_wdata  <= nx_data;
      bus_be     <= '1;
      beat_idx   <= 1'b1;
      misalign   <= 1'b0;
      range_trap <= 1'b0;
    end else if (accept) begin
      bus_valid  <= 1'b1;
      bus_write  <= req_store;
      bus_addr   <= req_addr;
      bus_wdata  <= st_data;
      bus_be     <= st_be;
      beat_idx   <= 1'b0;
      misalign   <= st_mis;
      range_trap <= st_trap;
      cur_size   <= in_size;
      cur_sgn    <= req_signed;
    end else begin
      bus_valid  <= 1'b0;
      bus_write  <= 1'b0;
      bus_be     <= '0;
      beat_idx   <= 1'b0;
      misalign   <= 1'b0;
      range_trap <= 1'b0;
    end
  end

  assign busy = second;

  lsa_load_extract u_load (
    .sz     (cur_size),
    .sgn    (cur_sgn),
    .off    (bus_addr[1:0]),
    .rdata  (bus_rdata),
    .result (ld_data)
  );

  assign ld_valid = bus_valid & ~bus_write & ~misalign;

endmodule

// File: rtl/lsa_unit_chk.sv
module lsa_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_be,
  input logic              beat_idx,
  input logic              ld_valid,
  input logic              misalign,
  input logic              range_trap
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> !bus_valid && !busy && bus_be == 4'h0);

  assert_idle_no_be_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> bus_be == 4'h0 && !beat_idx);

  assert_be_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> $countones(bus_be) != 3);

  assert_mis_no_be_R5: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> bus_valid && bus_be == 4'h0 && !busy);

  assert_trap_no_be_R6: assert property (@(posedge clk) disable iff (!rst_n)
    range_trap |-> bus_valid && bus_write && bus_be == 4'h0);

  assert_ld_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> bus_valid && !bus_write && !misalign);

  assert_busy_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> bus_valid && beat_idx && bus_be == 4'hF);

  assert_beat_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> bus_addr == $past(bus_addr) + ADDR_W'(4));

  assert_no_third_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

endmodule

bind lsa_unit lsa_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_addr   (bus_addr),
  .bus_be     (bus_be),
  .beat_idx   (beat_idx),
  .ld_valid   (ld_valid),
  .misalign   (misalign),
  .range_trap (range_trap)
);

// File: tb/lsa_unit_tb.sv
`timescale 1ns/1ps
module lsa_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_signed = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [31:0] bus_rdata = '0;
  logic        busy, bus_valid, bus_write, beat_idx, ld_valid, misalign, range_trap;
  logic [31:0] bus_addr, bus_wdata, ld_data;
  logic [3:0]  bus_be;

  int n_cmp = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  lsa_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
    .req_wdata(req_wdata), .bus_rdata(bus_rdata), .busy(busy),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .beat_idx(beat_idx),
    .ld_valid(ld_valid), .ld_data(ld_data), .misalign(misalign),
    .range_trap(range_trap)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Independent restatement of the requirements
  function automatic logic [3:0] want_be(int sz, int off);
    if (sz == 0) return 4'b1000 >> off;
    if (sz == 1) return (off >= 2) ? 4'b0011 : 4'b1100;
    return 4'b1111;
  endfunction

  function automatic bit want_mis(int sz, int off);
    if (sz == 0) return 0;
    if (sz == 1) return (off % 2) != 0;
    return off != 0;
  endfunction

  function automatic bit want_fit(int sz, bit sg, logic [31:0] v);
    longint s = longint'($signed(v));
    longint u = longint'(v);
    if (sz == 0) return sg ? (s >= -128 && s <= 127) : (u <= 255);
    if (sz == 1) return sg ? (s >= -32768 && s <= 32767) : (u <= 65535);
    return 1;
  endfunction

  function automatic logic [31:0] want_wdata(int sz, logic [31:0] v);
    if (sz == 0) return {4{v[7:0]}};
    if (sz == 1) return {2{v[15:0]}};
    return v;
  endfunction

  function automatic logic [31:0] want_load(int sz, bit sg, int off, logic [31:0] rd);
    logic [31:0] t;
    if (sz == 0) begin
      t = (rd >> (8 * (3 - off))) & 32'hFF;
      if (sg && t[7]) t = t | 32'hFFFF_FF00;
    end else if (sz == 1) begin
      t = (off >= 2) ? (rd & 32'hFFFF) : (rd >> 16);
      if (sg && t[15]) t = t | 32'hFFFF_0000;
    end else t = rd;
    return t;
  endfunction

  task automatic issue(input bit st, input int sz, input bit sg, input logic [31:0] a,
                       input logic [63:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_size = 2'(sz);
    req_signed = sg; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  logic [31:0] vals [15];
  logic [31:0] pats [4];

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_err++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    vals = '{32'd0, 32'd1, 32'd127, 32'd128, 32'd255, 32'd256, 32'd32767,
             32'd32768, 32'd65535, 32'd65536, 32'hFFFF_FFFF, 32'hFFFF_FF80,
             32'hFFFF_FF7F, 32'hFFFF_8000, 32'hFFFF_7FFF};
    pats = '{32'h8192_A3B4, 32'h0172_7F00, 32'hFF80_7FFF, 32'h1234_5678};

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 bus_valid", bus_valid, 0);
    check("R1 be", bus_be, 0);
    check("R1 busy", busy, 0);
    check("R1 flags", {ld_valid, misalign, range_trap, beat_idx}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {bus_valid, busy, bus_be}, 0);

    // Store sweep: R2 R3 R4 R5 R6
    for (int sz = 0; sz < 3; sz++)
      for (int sg = 0; sg < 2; sg++)
        for (int off = 0; off < 4; off++)
          for (int k = 0; k < 15; k++) begin
            logic [31:0] a;
            bit mis, fit;
            a = 32'h0000_1000 + 32'(off) + 32'(k * 16);
            mis = want_mis(sz, off);
            fit = want_fit(sz, sg[0], vals[k]);
            issue(1'b1, sz, sg[0], a, {32'hDEAD_BEEF, vals[k]});
            check("R2 valid/write", {bus_valid, bus_write}, 2'b11);
            check("R2 addr", bus_addr, a);
            check("R5 misalign", misalign, mis);
            check("R6 range_trap", range_trap, !fit);
            check("R3/R4 be", bus_be, (mis || !fit) ? 4'b0 : want_be(sz, off));
            if (!mis && fit) check("R3/R4 wdata", bus_wdata, want_wdata(sz, vals[k]));
          end

    // Idle cycle after a beat: R2
    @(negedge clk);
    check("R2 idle valid", bus_valid, 0);
    check("R2 idle be", bus_be, 0);

    // Load sweep: R7, R5 for loads, R6 loads never trap
    for (int sz = 0; sz < 3; sz++)
      for (int sg = 0; sg < 2; sg++)
        for (int off = 0; off < 4; off++)
          for (int p = 0; p < 4; p++) begin
            bit mis;
            mis = want_mis(sz, off);
            bus_rdata = pats[p];
            issue(1'b0, sz, sg[0], 32'h0000_2000 + 32'(off), 64'hFFFF_FFFF_FFFF_FFFF);
            check("R7 ld_valid", ld_valid, !mis);
            check("R6 load no trap", range_trap, 0);
            check("R5 load misalign", misalign, mis);
            if (!mis) check("R7 ld_data", ld_data, want_load(sz, sg[0], off, pats[p]));
          end

    // Aligned double-word store with a conflicting request in the busy cycle: R8 R9
    issue(1'b1, 3, 1'b0, 32'h0000_0100, 64'h1122_3344_5566_7788);
    check("R8 beat0 addr", bus_addr, 32'h100);
    check("R8 beat0 data", bus_wdata, 32'h1122_3344);
    check("R8 beat0 be", bus_be, 4'hF);
    check("R8 beat0 idx/busy", {beat_idx, busy}, 2'b01);
    req_valid = 1'b1; req_store = 1'b1; req_size = 2'd0;
    req_addr = 32'h200; req_wdata = 64'h0000_0000_0000_00AA;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 beat1 valid", bus_valid, 1);
    check("R9 beat1 addr", bus_addr, 32'h104);
    check("R9 beat1 data", bus_wdata, 32'h5566_7788);
    check("R8 beat1 be", bus_be, 4'hF);
    check("R8 beat1 idx/busy", {beat_idx, busy}, 2'b10);
    @(negedge clk);
    check("R9 ignored request", bus_valid, 0);

    // Misaligned double-word: no second beat, R5
    issue(1'b1, 3, 1'b0, 32'h0000_0102, 64'h1);
    check("R5 dword misalign", {misalign, bus_be, busy}, {1'b1, 4'h0, 1'b0});
    @(negedge clk);
    check("R5 no second beat", bus_valid, 0);

    // Double-word load: R8 R7
    bus_rdata = 32'hCAFE_0001;
    issue(1'b0, 3, 1'b1, 32'h0000_0300, 64'h0);
    check("R8 dword load beat0", {ld_valid, beat_idx, busy}, 3'b101);
    check("R7 dword load data0", ld_data, 32'hCAFE_0001);
    bus_rdata = 32'h8000_0002;
    @(negedge clk);
    check("R8 dword load beat1", {ld_valid, beat_idx, bus_addr}, {2'b11, 32'h304});
    check("R7 dword load data1", ld_data, 32'h8000_0002);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

endmodule